// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the control pins of a four-bank SDRAM interface. On each rising clock edge it samples chip select, the row strobe, the column strobe, the write enable, the bank address, address bit 10 and the clock enable. It decodes the command, checks it against a state it keeps for each bank and against two device-wide busy windows, and reports any violation. It is a passive observer: it drives nothing towards the memory and stores no data.

Each bank is idle, active or precharging. Device-wide, a refresh or a mode-register write opens a window that lasts a set number of clocks. Four clock counts are parameters: activate to access, precharge time, refresh cycle time and mode-set cycle time. A violation sets `err` for one cycle, in the cycle after the edge that sampled the command. `err_code` gives the reason: 1 means the bank is in the wrong state, 2 means a timing rule was broken, 3 means not all banks are idle, and 4 means the mode-set has a nonzero bank address. A command that is flagged changes no state.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With chip select high, no-operation (`cs_n`,`ras_n`,`cas_n`,`we_n` = 0111) or burst stop (0110) outside a mode-set window, the block raises no error and changes no state.
- R2: A read (0101) or write (0100) to a bank that is not active gives code 1.
- R3: An activate (0011) to an active bank gives code 1. An activate to a bank fewer than T_RP clocks after that bank's precharge gives code 2.
- R4: A read or write issued fewer than T_RCD clocks after the activate of its bank gives code 2.
- R5: A read or write with `a10` high moves the bank to precharging. The bank can be activated again T_RP clocks later.
- R6: A precharge (0010) closes the addressed bank when `a10` is low and closes every bank when `a10` is high. Banks that are already idle stay idle.
- R7: A refresh (0001) or mode-set (0000) while any bank is active, or still inside its precharge time, gives code 3.
- R8: A mode-set with a nonzero bank address gives code 4.
- R9: For T_RFC clocks after a refresh, any command other than deselect, no-operation or burst stop gives code 2.
- R10: For T_MRD clocks after a mode-set, any command other than deselect or no-operation gives code 2. This includes burst stop.
- R11: A sample taken with `cke` low is ignored. It causes no error and no state change.
- R12: `err` is registered one cycle after the offending edge and lasts one cycle for each offending command. `err_code` is 0 whenever `err` is low. Reset returns every bank to idle and clears both windows.
- R13: A flagged command does not change bank state and does not open a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Clock enable from the interface |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10: auto-precharge or all-bank select |
| err | output | 1 | Violation pulse |
| err_code | output | 3 | Violation reason: 1 bank state, 2 timing, 3 not all idle, 4 bad operand |

## Verification
The embedded properties check these rules on every cycle:
- quiet commands never raise an error;
- a non-quiet command inside the refresh window is flagged as a timing error;
- an activate to an open bank is flagged;
- an early read or write is flagged;
- `err` and `err_code` always agree.

Some behaviour can only be shown through the bench's command sequences, because it depends on what happens afterwards:
- the auto-precharge and precharge-all transitions;
- the exact clock at which each window closes;
- that a flagged mode-set opens no window;
- that a `cke`-low refresh leaves the banks untouched;
- that reset clears the bank state.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int BAW   = 2,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RFC = 4,
  parameter int T_MRD = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cke,
  input  logic           cs_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic [BAW-1:0] ba,
  input  logic           a10,
  output logic           err,
  output logic [2:0]     err_code
);
  localparam int NB   = 1 << BAW;
  localparam int M1   = T_RCD > T_RP ? T_RCD : T_RP;
  localparam int M2   = T_RFC > T_MRD ? T_RFC : T_MRD;
  localparam int TMAX = M1 > M2 ? M1 : M2;
  localparam int CW   = $clog2(TMAX + 1);

  localparam logic [1:0] S_IDLE = 2'd0, S_ACT = 2'd1, S_PRE = 2'd2;
  localparam logic [2:0] E_NONE = 3'd0, E_BANK = 3'd1, E_TIME = 3'd2,
                         E_BUSY = 3'd3, E_OPND = 3'd4;

  logic [1:0]    bst  [NB];
  logic [CW-1:0] bcnt [NB];
  logic [CW-1:0] ref_cnt, mrs_cnt;
  logic [NB-1:0] ready;
  logic [2:0]    code;

  wire live   = cke & ~cs_n;
  wire is_nop = live & ras_n & cas_n & we_n;
  wire is_bst = live & ras_n & cas_n & ~we_n;
  wire is_rw  = live & ras_n & ~cas_n;
  wire is_act = live & ~ras_n & cas_n & we_n;
  wire is_pre = live & ~ras_n & cas_n & ~we_n;
  wire is_ref = live & ~ras_n & ~cas_n & we_n;
  wire is_mrs = live & ~ras_n & ~cas_n & ~we_n;
  wire ref_busy  = ref_cnt != '0;
  wire mrs_busy  = mrs_cnt != '0;
  wire all_ready = &ready;
  wire ok        = live & (code == E_NONE);

  always_comb begin
    code = E_NONE;
    if (live) begin
      if (ref_busy && !(is_nop || is_bst))      code = E_TIME;
      else if (mrs_busy && !is_nop)             code = E_TIME;
      else if (is_rw) begin
        if (bst[ba] != S_ACT)                   code = E_BANK;
        else if (bcnt[ba] != '0)                code = E_TIME;
      end else if (is_act) begin
        if (bst[ba] == S_ACT)                   code = E_BANK;
        else if (!ready[ba])                    code = E_TIME;
      end else if (is_ref) begin
        if (!all_ready)                         code = E_BUSY;
      end else if (is_mrs) begin
        if (ba != '0)                           code = E_OPND;
        else if (!all_ready)                    code = E_BUSY;
      end
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    wire hit = ba == BAW'(i);
    assign ready[i] = (bst[i] == S_IDLE) || (bst[i] == S_PRE && bcnt[i] == '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bst[i]  <= S_IDLE;
        bcnt[i] <= '0;
      end else begin
        if (bcnt[i] != '0) bcnt[i] <= bcnt[i] - 1'b1;
        if (bst[i] == S_PRE && bcnt[i] == '0) bst[i] <= S_IDLE;
        if (ok && is_act && hit) begin
          bst[i]  <= S_ACT;
          bcnt[i] <= CW'(T_RCD - 1);
        end else if (ok && ((is_rw && hit && a10) ||
                            (is_pre && (hit || a10) && bst[i] == S_ACT))) begin
          bst[i]  <= S_PRE;
          bcnt[i] <= CW'(T_RP - 1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      mrs_cnt  <= '0;
      err      <= 1'b0;
      err_code <= E_NONE;
    end else begin
      ref_cnt  <= (ok && is_ref) ? CW'(T_RFC - 1) : (ref_busy ? ref_cnt - 1'b1 : ref_cnt);
      mrs_cnt  <= (ok && is_mrs) ? CW'(T_MRD - 1) : (mrs_busy ? mrs_cnt - 1'b1 : mrs_cnt);
      err      <= code != E_NONE;
      err_code <= code;
    end
  end

  // R1
  quiet_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke || cs_n || is_nop || (is_bst && !mrs_busy)) |=> !err);
  // R9
  ref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_busy && (is_rw || is_act || is_pre || is_ref || is_mrs)) |=> (err && err_code == E_TIME));
  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && !ref_busy && !mrs_busy && bst[ba] == S_ACT) |=> (err && err_code == E_BANK));
  // R4
  rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && !ref_busy && !mrs_busy && bst[ba] == S_ACT && bcnt[ba] != '0) |=> (err_code == E_TIME));
  // R12
  code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err == (err_code != E_NONE)) && (err_code <= E_OPND));
endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic err;
  logic [2:0] err_code;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .err(err), .err_code(err_code));

  // {cs,ras,cas,we, ba, a10, cke, expected code}
  localparam logic [10:0] VEC [35] = '{
    11'b0111_00_0_1_000, // R1 nop
    11'b0101_00_0_1_001, // R2 read idle bank
    11'b0011_00_0_1_000, // activate bank0
    11'b0101_00_0_1_010, // R4 read too early
    11'b0101_00_0_1_000, // R4 read on time
    11'b0011_00_0_1_001, // R3 activate open bank
    11'b0100_00_1_1_000, // R5 write auto-precharge
    11'b0011_00_0_1_010, // R3 activate inside precharge time
    11'b0011_00_0_1_000, // R5 activate after precharge time
    11'b0001_00_0_1_011, // R7 refresh with open bank
    11'b0011_01_0_1_000, // activate bank1
    11'b0010_00_1_1_000, // R6 precharge all
    11'b0000_00_0_1_011, // R7 mode-set while precharging
    11'b0000_10_0_1_100, // R8 bad bank bits; R13 no window opened
    11'b0000_00_0_1_000, // mode-set
    11'b0110_00_0_1_010, // R10 burst stop in mode-set window
    11'b0110_00_0_1_000, // R1 burst stop when idle
    11'b0001_00_0_1_000, // refresh
    11'b0111_00_0_1_000, // R9 nop in window
    11'b0110_00_0_1_000, // R9 burst stop in window
    11'b0011_10_0_1_010, // R9 activate in window
    11'b0011_10_0_1_000, // R9 window closed
    11'b1000_11_1_1_000, // R1 deselect
    11'b0001_00_0_0_000, // R11 refresh with cke low
    11'b0010_10_0_1_000, // R6 precharge bank2
    11'b0111_00_0_1_000,
    11'b0001_00_0_1_000, // R11 banks were untouched
    11'b0101_10_0_1_010, // R9 read in window
    11'b0111_00_0_1_000,
    11'b0111_00_0_1_000,
    11'b0101_11_0_1_001, // R2 read idle bank3
    11'b0011_11_0_1_000,
    11'b0111_00_0_1_000,
    11'b0100_11_0_1_000, // R4 write plain
    11'b0101_01_0_1_001  // R6 bank1 closed by precharge all
  };

  task automatic drive(input logic [10:0] v);
    {cs_n, ras_n, cas_n, we_n} = v[10:7];
    ba  = v[6:5];
    a10 = v[4];
    cke = v[3];
  endtask

  task automatic check(input string tag, input logic [2:0] exp);
    n_chk++;
    if (err !== (exp != 3'd0) || err_code !== exp) begin
      n_bad++;
      $display("FAIL %s: err=%0b code=%0d expected err=%0b code=%0d",
               tag, err, err_code, exp != 3'd0, exp);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset", 3'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 35; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("vector row %0d", i), VEC[i][2:0]);
    end
    // R12: one-cycle pulse then quiet
    drive(11'b0111_00_0_1_000);
    @(negedge clk);
    check("R12 pulse ends", 3'd0);
    // R12: reset clears bank state
    drive(11'b0011_01_0_1_000);
    @(negedge clk);
    check("R12 activate before reset", 3'd0);
    drive(11'b0111_00_0_1_000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(11'b0101_01_0_1_001);
    @(negedge clk);
    check("R12 bank idle after reset", 3'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule